// File: doc/BRIEF.md
# Two-Phase Toggle-Signalled Push Channel

This block carries data words from a local producer to a local consumer over a bundled-data link. The link has one data bus and two control wires. A transfer is marked only by a change of level on a control wire. A change from low to high counts the same as a change from high to low. A complete transfer therefore takes one request change and one acknowledge change, and neither wire ever returns to zero.

The sending half, the initiator, takes a word from a valid/ready source. It drives the word onto the bus and flips the request wire. It then holds the bus steady until it has registered a flip of the acknowledge wire. The receiving half, the receptor, detects the request flip by comparing the wire with its previous level and captures the bus in that same cycle. It presents the word to a valid/ready sink and flips the acknowledge wire only after the sink has taken the word. A slow sink therefore stalls the whole link. Both halves run in one clock domain, and the control levels are exposed so that the link can be observed.

Top module: `tp_channel`

## Requirements
- R1: While reset is asserted, the request and acknowledge levels are low, the bus is zero, `in_ready` is high and `out_valid` is low.
- R2: A source handshake (`in_valid` and `in_ready` high at a clock edge) flips `req_lvl` at that edge and places `in_data` on `bus_data`.
- R3: `in_ready` is low whenever `req_lvl` differs from `ack_lvl`. It is still low in the cycle after an acknowledge flip and is high in the cycle after that.
- R4: `bus_data` does not change from a request flip until the matching acknowledge flip.
- R5: One cycle after a request flip, `out_valid` is high and `out_data` equals the bus word that was signalled.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R7: `ack_lvl` flips at, and only at, an edge where `out_valid` and `out_ready` are both high.
- R8: Every source word reaches the sink exactly once and in order. Each transfer costs exactly one request flip and one acknowledge flip, in either direction, and a new request flip never arrives while a word is still held for the sink.
- R9: When the source offers a word in the first cycle after an acknowledge flip, the next request flip follows that acknowledge flip by exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Source offers a word |
| in_ready | output | 1 | Initiator is idle and can take a word |
| in_data | input | DATA_W | Word from the source |
| out_valid | output | 1 | Receptor holds a word for the sink |
| out_ready | input | 1 | Sink takes the held word |
| out_data | output | DATA_W | Word handed to the sink |
| req_lvl | output | 1 | Request wire level (initiator to receptor) |
| ack_lvl | output | 1 | Acknowledge wire level (receptor to initiator) |
| bus_data | output | DATA_W | Data bus between the halves |

## Verification
Two things can fall in the same cycle. The first is the source offering its next word. The second is the initiator absorbing the acknowledge flip that frees it. The bench keeps `in_valid` high through long and irregular sink stalls, so a word is waiting at the exact moment the acknowledge flip is registered. It then checks that `in_ready` does not rise early, that the bus stays frozen until the acknowledge, and that the next request flip lands exactly two edges after the acknowledge flip. Four passes each send all 256 byte values under different sink stall patterns and source gap patterns, and an arithmetic scoreboard confirms order and count.

// File: rtl/tp_chan_pkg.sv
package tp_chan_pkg;

    typedef enum logic {
        SIDE_IDLE = 1'b0,
        SIDE_BUSY = 1'b1
    } side_state_e;

    typedef struct packed {
        logic req;
        logic ack;
    } ctl_levels_t;

    function automatic logic level_changed(input logic now_lvl, input logic old_lvl);
        return now_lvl ^ old_lvl;
    endfunction

    function automatic side_state_e initiator_state(input ctl_levels_t lv);
        return (lv.req == lv.ack) ? SIDE_IDLE : SIDE_BUSY;
    endfunction

endpackage

// File: rtl/tp_edge_det.sv
module tp_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic evt,
    output logic prev
);
    import tp_chan_pkg::*;

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign prev = prev_q;
    assign evt  = level_changed(lvl, prev_q);
endmodule

// File: rtl/tp_initiator.sv
module tp_initiator #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    input  logic              ack_i,
    output logic              req_o,
    output logic [DATA_W-1:0] bus_o
);
    import tp_chan_pkg::*;

    logic              req_q;
    logic              ack_q;
    logic [DATA_W-1:0] bus_q;
    ctl_levels_t       lv;
    side_state_e       st;
    logic              take;

    assign lv.req    = req_q;
    assign lv.ack    = ack_q;
    assign st        = initiator_state(lv);
    assign src_ready = (st == SIDE_IDLE);
    assign take      = src_valid && src_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            ack_q <= 1'b0;
            bus_q <= '0;
        end else begin
            ack_q <= ack_i;
            if (take) begin
                bus_q <= src_data;
                req_q <= ~req_q;
            end
        end
    end

    assign req_o = req_q;
    assign bus_o = bus_q;
endmodule

// File: rtl/tp_receptor.sv
module tp_receptor #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic              ack_o,
    output logic              snk_valid,
    input  logic              snk_ready,
    output logic [DATA_W-1:0] snk_data
);
    import tp_chan_pkg::*;

    logic              req_evt;
    logic              req_prev;
    logic              full_q;
    logic              ack_q;
    logic [DATA_W-1:0] data_q;
    logic              give;
    side_state_e       st;

    tp_edge_det u_req_det (
        .clk  (clk),
        .rst  (rst),
        .lvl  (req_i),
        .evt  (req_evt),
        .prev (req_prev)
    );

    assign st   = full_q ? SIDE_BUSY : SIDE_IDLE;
    assign give = (st == SIDE_BUSY) && snk_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            ack_q  <= 1'b0;
            data_q <= '0;
        end else begin
            if (req_evt) begin
                data_q <= bus_i;
                full_q <= 1'b1;
            end else if (give) begin
                full_q <= 1'b0;
            end
            if (give) ack_q <= ~ack_q;
        end
    end

    assign ack_o     = ack_q;
    assign snk_valid = full_q;
    assign snk_data  = data_q;
endmodule

// File: rtl/tp_channel.sv
module tp_channel #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              req_lvl,
    output logic              ack_lvl,
    output logic [DATA_W-1:0] bus_data
);
    logic              req_w;
    logic              ack_w;
    logic [DATA_W-1:0] bus_w;

    tp_initiator #(.DATA_W(DATA_W)) u_init (
        .clk       (clk),
        .rst       (rst),
        .src_valid (in_valid),
        .src_ready (in_ready),
        .src_data  (in_data),
        .ack_i     (ack_w),
        .req_o     (req_w),
        .bus_o     (bus_w)
    );

    tp_receptor #(.DATA_W(DATA_W)) u_recv (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_w),
        .bus_i     (bus_w),
        .ack_o     (ack_w),
        .snk_valid (out_valid),
        .snk_ready (out_ready),
        .snk_data  (out_data)
    );

    assign req_lvl  = req_w;
    assign ack_lvl  = ack_w;
    assign bus_data = bus_w;
endmodule

// File: rtl/tp_channel_chk.sv
module tp_channel_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              req_lvl,
    input logic              ack_lvl,
    input logic [DATA_W-1:0] bus_data
);
    p_accept_flips_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (req_lvl != $past(req_lvl)) && (bus_data == $past(in_data)));

    p_busy_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        (req_lvl != ack_lvl) |-> !in_ready);

    p_bus_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (req_lvl != ack_lvl) |=> $stable(bus_data));

    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(req_lvl) |=> out_valid && (out_data == $past(bus_data)));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data));

    p_ack_on_take_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (ack_lvl != $past(ack_lvl)));

    p_ack_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_ready) |=> $stable(ack_lvl));

    p_no_overrun_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(req_lvl) |-> !$past(out_valid));
endmodule

bind tp_channel tp_channel_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .req_lvl   (req_lvl),
    .ack_lvl   (ack_lvl),
    .bus_data  (bus_data)
);

// File: tb/tp_channel_tb.sv
`timescale 1ns/1ps
module tp_channel_tb;
    localparam int DATA_W = 8;
    localparam int WORDS  = 256;
    localparam int PASSES = 4;
    localparam int LIMIT  = 150000;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic              in_ready;
    logic [DATA_W-1:0] in_data;
    logic              out_valid;
    logic              out_ready;
    logic [DATA_W-1:0] out_data;
    logic              req_lvl;
    logic              ack_lvl;
    logic [DATA_W-1:0] bus_data;

    int vectors = 0;
    int misses  = 0;
    int cyc     = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    tp_channel #(.DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .req_lvl(req_lvl), .ack_lvl(ack_lvl), .bus_data(bus_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [DATA_W-1:0] pat(input int pass, input int i);
        return DATA_W'((i * 37 + pass * 101) & 255);
    endfunction

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        logic p_req, p_ack, p_out_valid, p_out_ready, p_in_hs, p_out_hs;
        logic p_req_evt, p_ack_evt, ack_wait, expect_req;
        logic [DATA_W-1:0] p_in_data, p_out_data, bus_rec;
        logic req_evt, ack_evt;
        int idx, rx, req_cnt, ack_cnt;
        bit timeout;

        rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
        timeout = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(req_lvl == 1'b0, "R1 req_lvl", int'(req_lvl), 0);
        chk(ack_lvl == 1'b0, "R1 ack_lvl", int'(ack_lvl), 0);
        chk(bus_data == '0, "R1 bus_data", int'(bus_data), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        rst = 1'b0;

        p_req = 0; p_ack = 0; p_out_valid = 0; p_out_ready = 0;
        p_in_hs = 0; p_out_hs = 0; p_req_evt = 0; p_ack_evt = 0;
        ack_wait = 0; expect_req = 0;
        p_in_data = '0; p_out_data = '0; bus_rec = '0;

        for (int pass = 0; pass < PASSES && !timeout; pass++) begin
            idx = 0; rx = 0; req_cnt = 0; ack_cnt = 0;
            while (rx < WORDS && !timeout) begin
                @(negedge clk);
                cyc++;
                step_lfsr();
                if (cyc > LIMIT) begin
                    timeout = 1;
                    chk(1'b0, "watchdog", cyc, LIMIT);
                    break;
                end
                req_evt = (req_lvl != p_req);
                ack_evt = (ack_lvl != p_ack);
                if (req_evt) req_cnt++;
                if (ack_evt) ack_cnt++;

                // R2: handshake at last edge flips request and drives bus
                if (p_in_hs) begin
                    chk(req_evt, "R2 req flip", int'(req_lvl), int'(~p_req));
                    chk(bus_data == p_in_data, "R2 bus word", int'(bus_data), int'(p_in_data));
                end else begin
                    chk(!req_evt, "R2 no spurious req", int'(req_lvl), int'(p_req));
                end
                // R3: ready only when idle, one cycle after ack flip
                if (req_lvl != ack_lvl)
                    chk(!in_ready, "R3 busy ready", int'(in_ready), 0);
                if (ack_evt)
                    chk(!in_ready, "R3 ready lag", int'(in_ready), 0);
                if (p_ack_evt)
                    chk(in_ready, "R3 ready after ack", int'(in_ready), 1);
                // R4: bus frozen between request and acknowledge
                if (req_evt) bus_rec = bus_data;
                else if (req_lvl != ack_lvl)
                    chk(bus_data == bus_rec, "R4 bus hold", int'(bus_data), int'(bus_rec));
                // R5: capture one cycle after request flip
                if (p_req_evt) begin
                    chk(out_valid, "R5 out_valid", int'(out_valid), 1);
                    chk(out_data == bus_rec, "R5 out_data", int'(out_data), int'(bus_rec));
                end
                // R6: hold under stall
                if (p_out_valid && !p_out_ready) begin
                    chk(out_valid, "R6 valid hold", int'(out_valid), 1);
                    chk(out_data == p_out_data, "R6 data hold", int'(out_data), int'(p_out_data));
                end
                // R7: acknowledge flips exactly on sink handshake
                chk(ack_evt == p_out_hs, "R7 ack flip", int'(ack_evt), int'(p_out_hs));
                // R9: next request two edges after acknowledge
                if (expect_req)
                    chk(req_evt, "R9 req gap", int'(req_evt), 1);
                expect_req = 0;

                // producer
                if (p_in_hs) idx++;
                if (idx < WORDS) begin
                    if (!(in_valid && !p_in_hs)) begin
                        in_valid = (pass >= 2) ? (lfsr[2:1] != 2'b00) : 1'b1;
                        in_data  = pat(pass, idx);
                    end
                end else begin
                    in_valid = 1'b0;
                end
                if (ack_wait && in_valid) expect_req = 1;
                ack_wait = ack_evt;

                // consumer
                case (pass)
                    0: out_ready = 1'b1;
                    1: out_ready = lfsr[0];
                    2: out_ready = ((cyc / 7) % 3) != 0;
                    default: out_ready = cyc[0];
                endcase

                p_out_hs = out_valid && out_ready;
                if (p_out_hs) begin
                    // R8: in order, no loss, no duplicate
                    chk(out_data == pat(pass, rx), "R8 order", int'(out_data), int'(pat(pass, rx)));
                    rx++;
                end
                p_in_hs     = in_valid && in_ready;
                p_in_data   = in_data;
                p_req       = req_lvl;
                p_ack       = ack_lvl;
                p_req_evt   = req_evt;
                p_ack_evt   = ack_evt;
                p_out_valid = out_valid;
                p_out_ready = out_ready;
                p_out_data  = out_data;
            end
            if (!timeout) begin
                // let the last acknowledge settle
                @(negedge clk);
                cyc++;
                if (ack_lvl != p_ack) ack_cnt++;
                p_ack = ack_lvl;
                p_ack_evt = 1'b0;
                p_out_hs = 1'b0;
                p_in_hs = 1'b0;
                p_req_evt = 1'b0;
                p_out_valid = out_valid;
                ack_wait = 0;
                expect_req = 0;
                // R8: one request flip and one acknowledge flip per word
                chk(rx == WORDS, "R8 word count", rx, WORDS);
                chk(req_cnt == WORDS, "R8 req flips", req_cnt, WORDS);
                chk(ack_cnt == WORDS, "R8 ack flips", ack_cnt, WORDS);
                chk(req_lvl == ack_lvl, "R8 link idle", int'(ack_lvl), int'(req_lvl));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule